// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a bank of hardware semaphores that two ports, called left and right, share to guard common resources. The bank is separate from any data storage. A port reaches the bank through its own semaphore-select enable. The low bits of the port address pick one semaphore, and a write enable chooses between a read and a write. When a port writes, only bit 0 of its write data counts. A zero asks for the semaphore. A one gives the semaphore up, or withdraws a request that is still waiting.

Each semaphore records which side owns it (none, left or right) and keeps one waiting-request bit per side. A request made while the other side owns the semaphore is not refused outright. It is stored, and ownership passes to the waiting side in the same cycle the owner releases. When both ports ask for the same free semaphore in the same cycle, the left port gets it and the right request is stored as waiting. A read puts the port's view of the semaphore on every data bit: 0 if that port owns it and 1 otherwise. The value is captured in a per-port output register, so a write from the other side cannot disturb it.

Top module: `sem_bank2`

## Requirements
- R1: After reset all semaphores are free with no waiting requests, and both read-data outputs show all ones.
- R2: The semaphore index is address bits [2:0]. The higher address bits have no effect on which semaphore is accessed.
- R3: A port whose select is low has no effect on any semaphore, even with its write enable high.
- R4: A write looks only at write-data bit 0. A value of 0 is a request and a value of 1 is a release or cancel. All other data bits are ignored.
- R5: A request to a free semaphore makes the requester read all zeros and the other port read all ones.
- R6: A request from a port while the other port owns the semaphore changes neither view.
- R7: A waiting request is granted in the same cycle the owner writes 1. The next read shows the former waiter at all zeros and the former owner at all ones.
- R8: A non-owner that writes 1 cancels its waiting request. A later release by the owner then leaves the semaphore free.
- R9: Requests from both ports in the same cycle to a free semaphore grant it to the left port and store the right request as waiting.
- R10: A read captures the semaphore state as it was before any write in the same cycle. Read data then holds until that port's next read, and every bit carries the same value.
- R11: At most one side owns a semaphore. A waiting bit is set only while the opposite side is the owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left semaphore-select enable |
| l_wr | input | 1 | Left write (1) or read (0) |
| l_addr | input | ADDR_W | Left address; bits [2:0] pick the semaphore |
| l_wdata | input | DATA_W | Left write data; only bit 0 is used |
| l_rdata | output | DATA_W | Left captured read value |
| r_sel | input | 1 | Right semaphore-select enable |
| r_wr | input | 1 | Right write (1) or read (0) |
| r_addr | input | ADDR_W | Right address; bits [2:0] pick the semaphore |
| r_wdata | input | DATA_W | Right write data; only bit 0 is used |
| r_rdata | output | DATA_W | Right captured read value |

## Verification
The bench targets the cycle in which the owner releases while the other side is waiting. A design that drops the stored request would leave the semaphore free instead of handing it over. The bench also drives a same-cycle tie on a free semaphore, which a design without a fixed priority would grant to both sides or to neither. To test cancels, the bench withdraws a waiting request and then releases. Here a stale waiting bit would wrongly hand the semaphore over. The last scenario has one port read in the same cycle the other port's release grants it ownership. A design that read the post-write state, or kept tracking state after the read, would show 0 where the bench expects the captured 1.

// File: rtl/sem_pkg.sv
package sem_pkg;
   typedef enum logic [1:0] {OWN_NONE = 2'd0, OWN_L = 2'd1, OWN_R = 2'd2} sem_owner_e;

   typedef struct packed {
      sem_owner_e owner;
      logic       wait_l;
      logic       wait_r;
   } sem_st_t;

   localparam sem_st_t SEM_FREE = '{owner: OWN_NONE, wait_l: 1'b0, wait_r: 1'b0};

   // Apply one port's write of bit0 to a semaphore state.
   function automatic sem_st_t sem_step(sem_st_t s, logic is_right, logic bit0);
      sem_st_t    n;
      sem_owner_e me;
      sem_owner_e other;
      logic       other_wait;
      n          = s;
      me         = is_right ? OWN_R : OWN_L;
      other      = is_right ? OWN_L : OWN_R;
      other_wait = is_right ? s.wait_l : s.wait_r;
      if (!bit0) begin
         if (s.owner == OWN_NONE) n.owner = me;
         else if (s.owner != me) begin
            if (is_right) n.wait_r = 1'b1;
            else          n.wait_l = 1'b1;
         end
      end else begin
         if (is_right) n.wait_r = 1'b0;
         else          n.wait_l = 1'b0;
         if (s.owner == me) begin
            if (other_wait) begin
               n.owner = other;
               if (is_right) n.wait_l = 1'b0;
               else          n.wait_r = 1'b0;
            end else begin
               n.owner = OWN_NONE;
            end
         end
      end
      return n;
   endfunction
endpackage

// File: rtl/sem_cell.sv
module sem_cell
   import sem_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic l_hit,
   input  logic l_bit,
   input  logic r_hit,
   input  logic r_bit,
   output logic view_l,
   output logic view_r
);
   sem_st_t st, mid, nxt;

   always_comb begin
      mid = l_hit ? sem_step(st, 1'b0, l_bit) : st;
      nxt = r_hit ? sem_step(mid, 1'b1, r_bit) : mid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= SEM_FREE;
      else        st <= nxt;
   end

   assign view_l = (st.owner != OWN_L);
   assign view_r = (st.owner != OWN_R);

   assert_reset_free_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (st.owner == OWN_NONE && !st.wait_l && !st.wait_r));

   assert_wait_consistent_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!(st.wait_l && st.owner != OWN_R)) && (!(st.wait_r && st.owner != OWN_L)));

   assert_denied_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (r_hit && !r_bit && st.owner == OWN_L && !l_hit) |=> st.owner == OWN_L);

   assert_handoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (l_hit && l_bit && st.owner == OWN_L && st.wait_r && !r_hit) |=> st.owner == OWN_R);

   assert_tie_left_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (l_hit && !l_bit && r_hit && !r_bit && st.owner == OWN_NONE)
      |=> (st.owner == OWN_L && st.wait_r));
endmodule

// File: rtl/sem_rd_port.sv
module sem_rd_port #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              view,
   output logic [DATA_W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '1;
      else if (rd_en) rdata <= {DATA_W{view}};
   end

   assert_uniform_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata == '0) || (rdata == '1));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
endmodule

// File: rtl/sem_bank2.sv
module sem_bank2
   import sem_pkg::*;
#(
   parameter int NUM_SEM = 8,
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sel,
   input  logic              l_wr,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_sel,
   input  logic              r_wr,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata
);
   localparam int IDX_W = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1;

   if (NUM_SEM < 2 || (1 << IDX_W) != NUM_SEM) begin : g_bad_num
      $error("NUM_SEM must be a power of two of at least 2");
   end
   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the semaphore index");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end

   logic [IDX_W-1:0]   l_idx, r_idx;
   logic [NUM_SEM-1:0] vl, vr;

   assign l_idx = l_addr[IDX_W-1:0];
   assign r_idx = r_addr[IDX_W-1:0];

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
      sem_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .l_hit  (l_sel && l_wr && (l_idx == IDX_W'(i))),
         .l_bit  (l_wdata[0]),
         .r_hit  (r_sel && r_wr && (r_idx == IDX_W'(i))),
         .r_bit  (r_wdata[0]),
         .view_l (vl[i]),
         .view_r (vr[i])
      );
   end

   sem_rd_port #(.DATA_W(DATA_W)) u_rd_l (
      .clk(clk), .rst_n(rst_n), .rd_en(l_sel && !l_wr), .view(vl[l_idx]), .rdata(l_rdata));

   sem_rd_port #(.DATA_W(DATA_W)) u_rd_r (
      .clk(clk), .rst_n(rst_n), .rd_en(r_sel && !r_wr), .view(vr[r_idx]), .rdata(r_rdata));

   assert_single_owner_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (vl | vr) == '1);
endmodule

// File: tb/sem_bank2_tb.sv
module sem_bank2_tb;
   logic       clk = 0;
   logic       rst_n = 0;
   logic       l_sel = 0, l_wr = 0, r_sel = 0, r_wr = 0;
   logic [11:0] l_addr = '0, r_addr = '0;
   logic [7:0] l_wdata = '0, r_wdata = '0;
   logic [7:0] l_rdata, r_rdata;
   int         n_run = 0, n_fail = 0;

   always #4 clk = ~clk;

   sem_bank2 u_dut (.*);

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one cycle of port activity: drive after negedge, hold across posedge
   task automatic op(logic ls, logic lw, logic [11:0] la, logic [7:0] ld,
                     logic rs, logic rw, logic [11:0] ra, logic [7:0] rd);
      l_sel = ls; l_wr = lw; l_addr = la; l_wdata = ld;
      r_sel = rs; r_wr = rw; r_addr = ra; r_wdata = rd;
      @(negedge clk);
      l_sel = 0; l_wr = 0; r_sel = 0; r_wr = 0;
   endtask

   task automatic lw(int i, logic [7:0] d); op(1,1,12'(i),d, 0,0,0,0); endtask
   task automatic rw(int i, logic [7:0] d); op(0,0,0,0, 1,1,12'(i),d); endtask

   task automatic both_read(string tag, int i, logic el, logic er);
      op(1,0,12'(i),0, 1,0,12'(i),0);
      chk({tag," left"},  l_rdata, {8{el}});
      chk({tag," right"}, r_rdata, {8{er}});
   endtask

   task automatic t_reset;
      chk("R1 reset left rdata", l_rdata, 8'hFF);
      chk("R1 reset right rdata", r_rdata, 8'hFF);
      for (int i = 0; i < 8; i++) both_read("R1 free after reset", i, 1, 1);
   endtask

   task automatic t_decode;
      op(1,1,12'hA05,8'hFE, 0,0,0,0);
      both_read("R2 high bits ignored", 5, 0, 1);
      op(0,0,0,0, 0,1,12'h006,8'h00);
      both_read("R3 unselected write", 6, 1, 1);
      lw(5, 8'h01);
      both_read("R4 bit0=1 releases", 5, 1, 1);
      lw(5, 8'hFE);
      both_read("R4 bit0=0 requests", 5, 0, 1);
      lw(5, 8'hFF);
   endtask

   task automatic t_claim;
      rw(2, 8'h00);
      both_read("R5 right claims free", 2, 1, 0);
      rw(2, 8'h01);
   endtask

   task automatic t_deny_handoff;
      lw(1, 8'h00);
      rw(1, 8'h00);
      both_read("R6 denied request", 1, 0, 1);
      lw(1, 8'h01);
      both_read("R7 handoff to waiter", 1, 1, 0);
      rw(1, 8'h01);
      both_read("R7 free after release", 1, 1, 1);
   endtask

   task automatic t_cancel;
      lw(3, 8'h00);
      rw(3, 8'h00);
      rw(3, 8'h01);
      both_read("R8 cancel keeps owner", 3, 0, 1);
      lw(3, 8'h01);
      both_read("R8 free after cancel", 3, 1, 1);
   endtask

   task automatic t_tie;
      op(1,1,12'd7,8'h00, 1,1,12'd7,8'h00);
      both_read("R9 tie goes left", 7, 0, 1);
      lw(7, 8'h01);
      both_read("R9 right was waiting", 7, 1, 0);
      rw(7, 8'h01);
   endtask

   task automatic t_capture;
      rw(4, 8'h00);
      lw(4, 8'h00);
      op(0,0,0,0, 1,0,12'd4,0);
      chk("R10 right owner reads zero", r_rdata, 8'h00);
      op(1,0,12'd4,0, 1,1,12'd4,8'h01);
      chk("R10 left captured pre-write", l_rdata, 8'hFF);
      chk("R10 right holds without read", r_rdata, 8'h00);
      @(negedge clk);
      chk("R10 left holds", l_rdata, 8'hFF);
      both_read("R10 after handoff", 4, 0, 1);
      lw(4, 8'h01);
   endtask

   initial begin : wd
      repeat (5000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_decode;
      t_claim;
      t_deny_handoff;
      t_cancel;
      t_tie;
      t_capture;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule